// File: doc/BRIEF.md
# Sensor Readout Timing Generator

This block sequences the readout of a programmable window of a Bayer-patterned pixel array. It works in the pixel clock domain and advances one step on each cycle where the pixel-clock enable is high. Each step produces a row address and a column address for the array, a qualifier that marks the pixel as valid, and horizontal and vertical sync outputs. The addresses are the block's only output toward the array. A step can be an active pixel, a horizontal blanking step, or a step in a vertical blanking line.

All settings are plain input buses. They set the window origin and size, the blanking lengths, the Bayer-pair subsampling rate for each axis, a mirror flag for each axis, and, for each sync, its length, offset, polarity and pulse-or-level mode. The block copies all settings into shadow registers at reset and at each frame boundary. A frame in progress therefore never mixes old and new settings.

Top module: `sensor_readout_timing`

## Requirements
- R1: A line lasts the number of kept columns plus the effective horizontal blanking, counted in enabled steps. Kept columns come first, then blanking. For a width that is a multiple of 2*(column code+1), the number of kept columns is width/(column code+1).
- R2: A frame lasts the number of kept rows plus the effective vertical blanking, counted in lines. Kept rows come first, then the blank lines. Blank lines keep the full line length but have pix_valid low.
- R3: A horizontal blanking value below HB_MIN (60) is raised to HB_MIN. A vertical blanking value below VB_MIN (4) is raised to VB_MIN.
- R4: The window column origin has its bit 0 cleared. A non-mirrored line therefore starts at an even column. Every valid column address lies within [origin, origin+width).
- R5: The subsample code per axis is 0, 1, 2 or 3, selecting rate N = code+1. An offset o inside the window is kept exactly when floor(o/2) mod N is 0. This keeps one Bayer pair, then skips N-1 pairs.
- R6: With flip_h set, kept column offset o maps to origin+width-1-o, so the line runs right to left. flip_v does the same for rows, so the frame runs bottom to top. When clear, offsets map to origin+o.
- R7: In pulse mode, the horizontal sync is active for line steps p where hs_ofs <= p < hs_ofs+hs_len. Step 0 is the first kept pixel of the line.
- R8: In pulse mode, the vertical sync is active for whole lines l where vs_ofs <= l < vs_ofs+vs_len. Line 0 is the first line of the frame.
- R9: A polarity input of 0 gives an active-high sync. A polarity input of 1 inverts that sync.
- R10: In level mode (hs_lvl=1), the horizontal sync is active exactly while pix_valid is high. In level mode (vs_lvl=1), the vertical sync is active for every step of the kept-row lines.
- R11: Settings are sampled only at reset and on the step that ends a frame. Changing the inputs mid-frame has no effect until the next frame starts.
- R12: After reset, pix_valid and both addresses are 0, and each sync is at its inactive level. Outputs are registered and show a step one enabled cycle after the state it reflects. While dclk_en is low, nothing changes.
- R13: Whenever pix_valid is low, row_addr and col_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk_en | input | 1 | Pixel-clock step enable |
| win_row0 | input | ROW_W | Window row origin |
| win_col0 | input | COL_W | Window column origin (bit 0 ignored) |
| win_rows | input | ROW_W | Window depth in rows |
| win_cols | input | COL_W | Window width in columns |
| hblank | input | HB_W | Horizontal blanking steps |
| vblank | input | VB_W | Vertical blanking lines |
| row_skip | input | 2 | Row subsample code |
| col_skip | input | 2 | Column subsample code |
| flip_h | input | 1 | Right-to-left column scan |
| flip_v | input | 1 | Bottom-to-top row scan |
| hs_len | input | SYNC_W | Horizontal sync pulse length in steps |
| hs_ofs | input | HSO_W | Horizontal sync start step |
| hs_neg | input | 1 | Horizontal sync polarity (1 = active low) |
| hs_lvl | input | 1 | Horizontal sync as data-valid level |
| vs_len | input | SYNC_W | Vertical sync pulse length in lines |
| vs_ofs | input | VSO_W | Vertical sync start line |
| vs_neg | input | 1 | Vertical sync polarity (1 = active low) |
| vs_lvl | input | 1 | Vertical sync as row-valid level |
| pix_valid | output | 1 | Current step carries a kept pixel |
| row_addr | output | ROW_W | Array row address |
| col_addr | output | COL_W | Array column address |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The bench uses the default parameter values: ROW_W 9, COL_W 10, HB_MIN 60 and VB_MIN 4. The window inputs are kept small, from 6 to 12 rows and 8 to 16 columns, so a whole frame runs in a few hundred steps. With these settings, four back-to-back frames cover both blanking clamps, all four subsample codes across the two axes, mirroring on each axis, both sync polarities and both sync modes, and an odd column origin. Settings change mid-frame to show the frame-boundary latch. The enable is gated in a one-in-three pattern during the third frame to show the hold behaviour.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // Bayer-pair subsample rate, encoded as rate minus one
  typedef enum logic [1:0] {
    SUB_X1 = 2'd0,
    SUB_X2 = 2'd1,
    SUB_X3 = 2'd2,
    SUB_X4 = 2'd3
  } sub_rate_e;

  // Offset jump after the second pixel of a kept pair: 2*rate - 1
  function automatic logic [3:0] pair_jump(input sub_rate_e r);
    return {1'b0, r, 1'b1};
  endfunction

endpackage

// File: rtl/srt_pair_walk.sv
// Walks window offsets in Bayer pairs: keep a pair, skip rate-1 pairs.
module srt_pair_walk
  import srt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         restart,
  input  logic         advance,
  input  sub_rate_e    rate,
  input  logic [W-1:0] limit,
  output logic [W-1:0] off,
  output logic         last
);

  logic [W:0] off_q;
  logic [W:0] nxt;
  logic       odd_q;

  always_comb begin
    nxt = off_q + (odd_q ? (W+1)'(pair_jump(rate)) : (W+1)'(1));
  end

  assign last = (nxt >= {1'b0, limit});
  assign off  = off_q[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      odd_q <= 1'b0;
    end else if (step_en) begin
      if (restart) begin
        off_q <= '0;
        odd_q <= 1'b0;
      end else if (advance) begin
        off_q <= nxt;
        odd_q <= ~odd_q;
      end
    end
  end

  // R5: the walk never leaves the window
  p_off_below_limit_r5: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (off_q < {1'b0, limit}));

endmodule

// File: rtl/srt_sync_gen.sv
// One sync output: pulse over a position window, or a level, with polarity.
module srt_sync_gen #(
  parameter int PW = 15,
  parameter int SW = 10,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          rst_pol,
  input  logic [PW-1:0] pos,
  input  logic [SW-1:0] start,
  input  logic [LW-1:0] len,
  input  logic          level_mode,
  input  logic          level_act,
  input  logic          pol,
  output logic          sync_o
);

  localparam int EW = PW + 1;

  logic [EW-1:0] lo, hi, p;
  logic          act;

  always_comb begin
    lo  = EW'(start);
    hi  = EW'(start) + EW'(len);
    p   = EW'(pos);
    act = level_mode ? level_act : ((p >= lo) && (p < hi));
  end

  always_ff @(posedge clk) begin
    if (rst)          sync_o <= rst_pol;
    else if (step_en) sync_o <= act ^ pol;
  end

endmodule

// File: rtl/sensor_readout_timing.sv
module sensor_readout_timing
  import srt_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 10,
  parameter int HB_W   = 14,
  parameter int VB_W   = 13,
  parameter int SYNC_W = 8,
  parameter int HSO_W  = 10,
  parameter int VSO_W  = 10,
  parameter int HB_MIN = 60,
  parameter int VB_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dclk_en,
  input  logic [ROW_W-1:0]  win_row0,
  input  logic [COL_W-1:0]  win_col0,
  input  logic [ROW_W-1:0]  win_rows,
  input  logic [COL_W-1:0]  win_cols,
  input  logic [HB_W-1:0]   hblank,
  input  logic [VB_W-1:0]   vblank,
  input  logic [1:0]        row_skip,
  input  logic [1:0]        col_skip,
  input  logic              flip_h,
  input  logic              flip_v,
  input  logic [SYNC_W-1:0] hs_len,
  input  logic [HSO_W-1:0]  hs_ofs,
  input  logic              hs_neg,
  input  logic              hs_lvl,
  input  logic [SYNC_W-1:0] vs_len,
  input  logic [VSO_W-1:0]  vs_ofs,
  input  logic              vs_neg,
  input  logic              vs_lvl,
  output logic              pix_valid,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              hsync,
  output logic              vsync
);

  localparam int HPOS_W = HB_W + 1;
  localparam int VPOS_W = VB_W + 1;

  // shadow settings, loaded at reset and at each frame end
  logic [ROW_W-1:0]  s_r0, s_d;
  logic [COL_W-1:0]  s_c0, s_w;
  logic [HB_W-1:0]   s_hb;
  logic [VB_W-1:0]   s_vb;
  logic [1:0]        s_rsub, s_csub;
  logic              s_fh, s_fv;
  logic [SYNC_W-1:0] s_hsl, s_vsl;
  logic [HSO_W-1:0]  s_hso;
  logic [VSO_W-1:0]  s_vso;
  logic              s_hneg, s_hlvl, s_vneg, s_vlvl;

  // scan state
  logic              h_act, v_act;
  logic [HB_W-1:0]   hb_cnt;
  logic [VB_W-1:0]   vb_cnt;
  logic [HPOS_W-1:0] hpos;
  logic [VPOS_W-1:0] vline;

  logic line_end, frame_end, px_now;
  logic [COL_W-1:0] c_off, c_map;
  logic [ROW_W-1:0] r_off, r_map;
  logic c_last, r_last;

  assign line_end  = !h_act && (hb_cnt == '0);
  assign frame_end = line_end && !v_act && (vb_cnt == '0);
  assign px_now    = h_act && v_act;

  always_ff @(posedge clk) begin
    if (rst || (dclk_en && frame_end)) begin
      s_r0   <= win_row0;
      s_c0   <= {win_col0[COL_W-1:1], 1'b0};
      s_d    <= win_rows;
      s_w    <= win_cols;
      s_hb   <= (hblank < HB_W'(HB_MIN)) ? HB_W'(HB_MIN) : hblank;
      s_vb   <= (vblank < VB_W'(VB_MIN)) ? VB_W'(VB_MIN) : vblank;
      s_rsub <= row_skip;
      s_csub <= col_skip;
      s_fh   <= flip_h;
      s_fv   <= flip_v;
      s_hsl  <= hs_len;
      s_hso  <= hs_ofs;
      s_hneg <= hs_neg;
      s_hlvl <= hs_lvl;
      s_vsl  <= vs_len;
      s_vso  <= vs_ofs;
      s_vneg <= vs_neg;
      s_vlvl <= vs_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_act  <= 1'b1;
      v_act  <= 1'b1;
      hb_cnt <= '0;
      vb_cnt <= '0;
      hpos   <= '0;
      vline  <= '0;
    end else if (dclk_en) begin
      if (h_act) begin
        hpos <= hpos + 1'b1;
        if (c_last) begin
          h_act  <= 1'b0;
          hb_cnt <= s_hb - 1'b1;
        end
      end else if (hb_cnt != '0) begin
        hpos   <= hpos + 1'b1;
        hb_cnt <= hb_cnt - 1'b1;
      end else begin
        hpos  <= '0;
        h_act <= 1'b1;
        if (v_act) begin
          vline <= vline + 1'b1;
          if (r_last) begin
            v_act  <= 1'b0;
            vb_cnt <= s_vb - 1'b1;
          end
        end else if (vb_cnt != '0) begin
          vline  <= vline + 1'b1;
          vb_cnt <= vb_cnt - 1'b1;
        end else begin
          vline <= '0;
          v_act <= 1'b1;
        end
      end
    end
  end

  srt_pair_walk #(.W(COL_W)) u_col_walk (
    .clk(clk), .rst(rst), .step_en(dclk_en),
    .restart(line_end), .advance(h_act && !c_last),
    .rate(sub_rate_e'(s_csub)), .limit(s_w),
    .off(c_off), .last(c_last)
  );

  srt_pair_walk #(.W(ROW_W)) u_row_walk (
    .clk(clk), .rst(rst), .step_en(dclk_en),
    .restart(frame_end), .advance(line_end && v_act && !r_last),
    .rate(sub_rate_e'(s_rsub)), .limit(s_d),
    .off(r_off), .last(r_last)
  );

  always_comb begin
    c_map = s_fh ? (s_c0 + (s_w - 1'b1 - c_off)) : (s_c0 + c_off);
    r_map = s_fv ? (s_r0 + (s_d - 1'b1 - r_off)) : (s_r0 + r_off);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      col_addr  <= '0;
      row_addr  <= '0;
    end else if (dclk_en) begin
      pix_valid <= px_now;
      col_addr  <= px_now ? c_map : '0;
      row_addr  <= px_now ? r_map : '0;
    end
  end

  srt_sync_gen #(.PW(HPOS_W), .SW(HSO_W), .LW(SYNC_W)) u_hs (
    .clk(clk), .rst(rst), .step_en(dclk_en), .rst_pol(hs_neg),
    .pos(hpos), .start(s_hso), .len(s_hsl),
    .level_mode(s_hlvl), .level_act(px_now), .pol(s_hneg),
    .sync_o(hsync)
  );

  srt_sync_gen #(.PW(VPOS_W), .SW(VSO_W), .LW(SYNC_W)) u_vs (
    .clk(clk), .rst(rst), .step_en(dclk_en), .rst_pol(vs_neg),
    .pos(vline), .start(s_vso), .len(s_vsl),
    .level_mode(s_vlvl), .level_act(v_act), .pol(s_vneg),
    .sync_o(vsync)
  );

  // R1: line position stays inside one line period
  p_hpos_bound_r1: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, hpos} < ((HPOS_W+1)'(s_w) + (HPOS_W+1)'(s_hb))));

  // R2: line index stays inside one frame period
  p_vline_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, vline} < ((VPOS_W+1)'(s_d) + (VPOS_W+1)'(s_vb))));

  // R4: valid column addresses fall inside the window
  p_col_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (({1'b0, s_c0} + {1'b0, s_w}) <= (COL_W+1)'(2**COL_W)))
    |-> ((col_addr >= s_c0) && ({1'b0, col_addr} < ({1'b0, s_c0} + {1'b0, s_w}))));

  // R10: level-mode horizontal sync tracks the valid qualifier
  p_hs_level_r10: assert property (@(posedge clk) disable iff (rst)
    (dclk_en && s_hlvl) |=> (hsync == (pix_valid ^ $past(s_hneg))));

  // R12: outputs hold while the enable is low
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !dclk_en |=> ($stable(pix_valid) && $stable(hsync) && $stable(vsync) &&
                  $stable(col_addr) && $stable(row_addr)));

endmodule

// File: tb/sensor_readout_timing_bench.sv
`timescale 1ns/1ps
module sensor_readout_timing_bench;

  typedef struct packed {
    logic       v;
    logic [8:0] r;
    logic [9:0] c;
    logic       hs;
    logic       vs;
  } item_t;

  typedef struct {
    int rs, cs, d, w, hb, vb, rsub, csub, mh, mv;
    int hsl, hso, hneg, hlvl, vsl, vso, vneg, vlvl;
  } cfg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dclk_en = 1'b0;
  logic [8:0] win_row0, win_rows;
  logic [9:0] win_col0, win_cols;
  logic [13:0] hblank;
  logic [12:0] vblank;
  logic [1:0] row_skip, col_skip;
  logic flip_h, flip_v, hs_neg, hs_lvl, vs_neg, vs_lvl;
  logic [7:0] hs_len, vs_len;
  logic [9:0] hs_ofs, vs_ofs;
  logic pix_valid, hsync, vsync;
  logic [8:0] row_addr;
  logic [9:0] col_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  sensor_readout_timing u_sensor_readout_timing (
    .clk(clk), .rst(rst), .dclk_en(dclk_en),
    .win_row0(win_row0), .win_col0(win_col0), .win_rows(win_rows), .win_cols(win_cols),
    .hblank(hblank), .vblank(vblank), .row_skip(row_skip), .col_skip(col_skip),
    .flip_h(flip_h), .flip_v(flip_v),
    .hs_len(hs_len), .hs_ofs(hs_ofs), .hs_neg(hs_neg), .hs_lvl(hs_lvl),
    .vs_len(vs_len), .vs_ofs(vs_ofs), .vs_neg(vs_neg), .vs_lvl(vs_lvl),
    .pix_valid(pix_valid), .row_addr(row_addr), .col_addr(col_addr),
    .hsync(hsync), .vsync(vsync)
  );

  task automatic apply_cfg(input cfg_t k);
    win_row0 = 9'(k.rs);  win_col0 = 10'(k.cs);
    win_rows = 9'(k.d);   win_cols = 10'(k.w);
    hblank = 14'(k.hb);   vblank = 13'(k.vb);
    row_skip = 2'(k.rsub); col_skip = 2'(k.csub);
    flip_h = (k.mh != 0); flip_v = (k.mv != 0);
    hs_len = 8'(k.hsl); hs_ofs = 10'(k.hso); hs_neg = (k.hneg != 0); hs_lvl = (k.hlvl != 0);
    vs_len = 8'(k.vsl); vs_ofs = 10'(k.vso); vs_neg = (k.vneg != 0); vs_lvl = (k.vlvl != 0);
  endtask

  // Driver: expands one frame of a setting into expected steps (R1, R2, R3, R5, R6, R7-R10, R13)
  task automatic push_frame(input cfg_t k, output int len);
    int cols[$];
    int rows[$];
    int hb, vb, c0, na, nr;
    item_t it;
    len = 0;
    for (int o = 0; o < k.w; o++) if (((o / 2) % (k.csub + 1)) == 0) cols.push_back(o);
    for (int o = 0; o < k.d; o++) if (((o / 2) % (k.rsub + 1)) == 0) rows.push_back(o);
    hb = (k.hb < 60) ? 60 : k.hb;        // R3
    vb = (k.vb < 4) ? 4 : k.vb;          // R3
    c0 = k.cs - (k.cs % 2);              // R4
    na = cols.size();
    nr = rows.size();
    for (int l = 0; l < nr + vb; l++) begin
      for (int h = 0; h < na + hb; h++) begin
        logic ha, va, hpulse, vpulse;
        ha = (h < na);
        va = (l < nr);
        it.v = ha && va;
        it.c = it.v ? 10'(k.mh != 0 ? c0 + k.w - 1 - cols[h] : c0 + cols[h]) : 10'd0;
        it.r = it.v ? 9'(k.mv != 0 ? k.rs + k.d - 1 - rows[l] : k.rs + rows[l]) : 9'd0;
        hpulse = (k.hlvl != 0) ? it.v : ((h >= k.hso) && (h < k.hso + k.hsl));
        vpulse = (k.vlvl != 0) ? va : ((l >= k.vso) && (l < k.vso + k.vsl));
        it.hs = hpulse ^ (k.hneg != 0);
        it.vs = vpulse ^ (k.vneg != 0);
        exp_q.push_back(it);
        len++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Monitor: pops one expected step per enabled edge and compares
  initial begin
    cfg_t ca, cb, cc;
    int la, lb, lc, la2, popped, cyc;
    bit prev_en;
    item_t e, last_seen;

    ca = '{rs:14, cs:15, d:6, w:8, hb:70, vb:5, rsub:0, csub:0, mh:0, mv:0,
           hsl:4, hso:2, hneg:0, hlvl:0, vsl:2, vso:1, vneg:1, vlvl:0};
    cb = '{rs:3, cs:20, d:12, w:12, hb:10, vb:1, rsub:2, csub:1, mh:1, mv:1,
           hsl:8, hso:0, hneg:1, hlvl:1, vsl:1, vso:0, vneg:0, vlvl:0};
    cc = '{rs:100, cs:33, d:8, w:16, hb:64, vb:6, rsub:1, csub:3, mh:0, mv:1,
           hsl:3, hso:5, hneg:0, hlvl:0, vsl:3, vso:2, vneg:1, vlvl:1};

    push_frame(ca, la);
    push_frame(cb, lb);
    push_frame(cc, lc);
    push_frame(ca, la2);

    apply_cfg(ca);
    rst = 1'b1;
    dclk_en = 1'b0;
    repeat (3) @(negedge clk);

    // R12 R13: reset state
    checks++;
    if (pix_valid !== 1'b0 || row_addr !== 9'd0 || col_addr !== 10'd0 ||
        hsync !== 1'b0 || vsync !== 1'b1) begin
      failures++;
      $display("FAIL R12 reset: actual v=%0b r=%0d c=%0d hs=%0b vs=%0b expected v=0 r=0 c=0 hs=0 vs=1",
               pix_valid, row_addr, col_addr, hsync, vsync);
    end
    last_seen = {pix_valid, row_addr, col_addr, hsync, vsync};

    rst = 1'b0;
    dclk_en = 1'b1;
    prev_en = 1'b1;
    popped = 0;
    cyc = 0;

    while (exp_q.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (prev_en) begin
        e = exp_q.pop_front();
        checks++;
        if (pix_valid !== e.v) begin
          failures++;
          $display("FAIL R1 R2 R3 R11 valid step %0d: actual=%0b expected=%0b", popped, pix_valid, e.v);
        end else if (col_addr !== e.c) begin
          failures++;
          $display("FAIL R4 R5 R6 R13 col step %0d: actual=%0d expected=%0d", popped, col_addr, e.c);
        end else if (row_addr !== e.r) begin
          failures++;
          $display("FAIL R5 R6 R13 row step %0d: actual=%0d expected=%0d", popped, row_addr, e.r);
        end else if (hsync !== e.hs) begin
          failures++;
          $display("FAIL R7 R9 R10 hsync step %0d: actual=%0b expected=%0b", popped, hsync, e.hs);
        end else if (vsync !== e.vs) begin
          failures++;
          $display("FAIL R8 R9 R10 vsync step %0d: actual=%0b expected=%0b", popped, vsync, e.vs);
        end
        popped++;
        // R11: settings change mid-frame, take effect at the next frame
        if (popped == la / 2) apply_cfg(cb);
        if (popped == la + lb / 2) apply_cfg(cc);
        if (popped == la + lb + lc / 2) apply_cfg(ca);
      end else begin
        // R12: no change while the enable was low
        checks++;
        if ({pix_valid, row_addr, col_addr, hsync, vsync} !== last_seen) begin
          failures++;
          $display("FAIL R12 hold step %0d: actual=%h expected=%h", popped,
                   {pix_valid, row_addr, col_addr, hsync, vsync}, last_seen);
        end
      end
      last_seen = {pix_valid, row_addr, col_addr, hsync, vsync};
      if (popped >= la + lb && popped < la + lb + lc) dclk_en = ((cyc % 3) != 0);
      else dclk_en = 1'b1;
      prev_en = dclk_en;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule